// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit chooses the program counter for the following instruction in a 32-bit single-cycle processor. It takes the current PC, the 26-bit direct jump field, the immediate (already sign-extended to 32 bits), the two register operands and the decoder's control lines. It produces the next PC and the sequential address PC+4. PC+4 also serves as the return address that a jump-and-link writes back.

Five branch conditions are resolved inside the unit and selected by a 3-bit kind code: equal, not equal, signed less-than, not zero and signed greater-or-equal-zero. A target can come from three places: a register, a pseudo-direct jump or a branch offset. When more than one is requested, a fixed priority picks one. All address arithmetic wraps modulo 2^32.

Top module: `npc_unit`

## Requirements
- R1: `link_o` always equals `pc_i + 4`, with any carry out of bit 31 discarded.
- R2: When `jreg_i`, `jump_i` and `branch_i` are all 0, `next_pc_o` equals `pc_i + 4`.
- R3: A taken branch sets `next_pc_o` to `pc_i + 4 + (imm_i << 2)`, truncated to 32 bits, so the address wraps modulo 2^32.
- R4: Kind code 3'd0 (equal) is taken when `rs_val_i == rt_val_i`. Kind code 3'd1 (not equal) is taken when they differ.
- R5: Kind code 3'd2 (less-than) is taken when `rs_val_i < rt_val_i` under a signed two's-complement comparison.
- R6: Kind code 3'd3 (not zero) is taken when `rs_val_i != 0`. Kind code 3'd4 (greater-or-equal-zero) is taken when `rs_val_i` is non-negative as a signed value, which means bit 31 is 0.
- R7: When `branch_i` is 0, the branch condition has no effect on `next_pc_o`.
- R8: When `jump_i` is 1 and `jreg_i` is 0, `next_pc_o` is `{pc_i[31:28], jaddr_i, 2'b00}`.
- R9: When `jreg_i` is 1, `next_pc_o` equals `rs_val_i`.
- R10: Priority is register jump, then direct jump, then taken branch, then PC+4.
- R11: Kind codes 3'd5 to 3'd7 are never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter |
| jaddr_i | input | 26 | Direct jump address field |
| imm_i | input | 32 | Sign-extended branch immediate |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| branch_i | input | 1 | Instruction is a conditional branch |
| br_kind_i | input | 3 | Branch condition selector |
| jump_i | input | 1 | Pseudo-direct jump |
| jreg_i | input | 1 | Jump to register value |
| next_pc_o | output | 32 | Selected next program counter |
| link_o | output | 32 | PC+4, used as the return address |

## Verification
The assertions are immediate checks that assume every input settles together between evaluations. They treat each input combination as legal, including several control lines asserted at once and kind codes outside the five defined ones. The stimulus applies one full set of inputs shortly after a clock edge and samples at the following falling edge. This means no check ever sees a partly updated input set. The random phase draws the controls and the kind code over their full ranges. The directed phase places operands at the signed boundaries and the PC at the top of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    BK_EQ  = 3'd0,
    BK_NE  = 3'd1,
    BK_LT  = 3'd2,
    BK_NZ  = 3'd3,
    BK_GEZ = 3'd4
  } br_kind_e;

  localparam int unsigned NUM_KINDS = 8;

  // signed less-than built from the sign bits and the unsigned difference
  function automatic logic f_slt(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] diff;
    diff = {1'b0, a} - {1'b0, b};
    if (a[31] != b[31]) return a[31];
    return diff[32];
  endfunction

  function automatic logic [31:0] f_word_offset(input logic [31:0] imm);
    return {imm[29:0], 2'b00};
  endfunction

endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] plus4_o,
  output logic [XLEN-1:0] br_tgt_o
);
  import npc_pkg::*;

  localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);

  always_comb begin
    plus4_o  = pc_i + STEP_W;
    br_tgt_o = plus4_o + f_word_offset(imm_i);
  end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            hit_o
);
  import npc_pkg::*;

  logic [NUM_KINDS-1:0] hits;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    if (k == int'(BK_EQ)) begin : g_eq
      assign hits[k] = (rs_i == rt_i);
    end else if (k == int'(BK_NE)) begin : g_ne
      assign hits[k] = (rs_i != rt_i);
    end else if (k == int'(BK_LT)) begin : g_lt
      assign hits[k] = f_slt(rs_i, rt_i);
    end else if (k == int'(BK_NZ)) begin : g_nz
      assign hits[k] = |rs_i;
    end else if (k == int'(BK_GEZ)) begin : g_gez
      assign hits[k] = ~rs_i[XLEN-1];
    end else begin : g_rsv
      assign hits[k] = 1'b0;
    end
  end

  assign hit_o = hits[kind_i];

endmodule

// File: rtl/npc_pick.sv
module npc_pick #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned JFIELD = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JFIELD-1:0] jaddr_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   plus4_i,
  input  logic [XLEN-1:0]   br_tgt_i,
  input  logic              br_taken_i,
  input  logic              jump_i,
  input  logic              jreg_i,
  output logic [XLEN-1:0]   jmp_tgt_o,
  output logic [XLEN-1:0]   next_o
);
  localparam int unsigned REGION = XLEN - JFIELD - 2;

  assign jmp_tgt_o = {pc_i[XLEN-1 -: REGION], jaddr_i, 2'b00};

  always_comb begin
    if (jreg_i)          next_o = rs_i;
    else if (jump_i)     next_o = jmp_tgt_o;
    else if (br_taken_i) next_o = br_tgt_i;
    else                 next_o = plus4_i;
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned JFIELD = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JFIELD-1:0] jaddr_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic              branch_i,
  input  logic [2:0]        br_kind_i,
  input  logic              jump_i,
  input  logic              jreg_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   link_o
);

  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic            cond_true;
  logic            br_taken;

  npc_seq_adder #(.XLEN(XLEN)) u_add (
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .plus4_o  (pc_plus4),
    .br_tgt_o (br_target)
  );

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind_i (br_kind_i),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .hit_o  (cond_true)
  );

  assign br_taken = branch_i & cond_true;

  npc_pick #(.XLEN(XLEN), .JFIELD(JFIELD)) u_pick (
    .pc_i       (pc_i),
    .jaddr_i    (jaddr_i),
    .rs_i       (rs_val_i),
    .plus4_i    (pc_plus4),
    .br_tgt_i   (br_target),
    .br_taken_i (br_taken),
    .jump_i     (jump_i),
    .jreg_i     (jreg_i),
    .jmp_tgt_o  (jmp_target),
    .next_o     (next_pc_o)
  );

  assign link_o = pc_plus4;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic [31:0] pc_i,
  input logic [25:0] jaddr_i,
  input logic [31:0] imm_i,
  input logic [31:0] rs_val_i,
  input logic        branch_i,
  input logic [2:0]  br_kind_i,
  input logic        jump_i,
  input logic        jreg_i,
  input logic [31:0] next_pc_o,
  input logic [31:0] link_o,
  input logic        cond_true,
  input logic        br_taken
);

  always_comb begin
    // R9
    rj_next_chk: assert (!jreg_i || next_pc_o == rs_val_i)
      else $error("register jump target mismatch");
    // R8
    dj_region_chk: assert (jreg_i || !jump_i ||
                           (next_pc_o[31:28] == pc_i[31:28] && next_pc_o[1:0] == 2'b00 &&
                            next_pc_o[27:2] == jaddr_i))
      else $error("direct jump target mismatch");
    // R2
    seq_next_chk: assert (jreg_i || jump_i || branch_i || next_pc_o == link_o)
      else $error("sequential next pc mismatch");
    // R7
    gate_chk: assert (branch_i || !br_taken)
      else $error("branch taken without branch control");
    // R3
    offset_chk: assert (jreg_i || jump_i || !br_taken ||
                        (next_pc_o - link_o) == {imm_i[29:0], 2'b00})
      else $error("branch offset mismatch");
    // R11
    rsv_kind_chk: assert (br_kind_i < 3'd5 || !cond_true)
      else $error("reserved kind produced a hit");
    // R6
    gez_sign_chk: assert (br_kind_i != 3'd4 || cond_true == !rs_val_i[31])
      else $error("gez condition mismatch");
  end

endmodule

bind npc_unit npc_unit_chk u_chk (
  .pc_i      (pc_i),
  .jaddr_i   (jaddr_i),
  .imm_i     (imm_i),
  .rs_val_i  (rs_val_i),
  .branch_i  (branch_i),
  .br_kind_i (br_kind_i),
  .jump_i    (jump_i),
  .jreg_i    (jreg_i),
  .next_pc_o (next_pc_o),
  .link_o    (link_o),
  .cond_true (cond_true),
  .br_taken  (br_taken)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, imm, rs, rt;
  logic [25:0] ja;
  logic        br, jp, jr;
  logic [2:0]  kind;
  logic [31:0] next_pc, link;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [31:0] nxt;
    logic [31:0] lnk;
    string       tag;
  } exp_t;

  exp_t sb[$];
  bit   done = 0;

  always #5 clk = ~clk;

  npc_unit u_dut (
    .pc_i(pc), .jaddr_i(ja), .imm_i(imm), .rs_val_i(rs), .rt_val_i(rt),
    .branch_i(br), .br_kind_i(kind), .jump_i(jp), .jreg_i(jr),
    .next_pc_o(next_pc), .link_o(link)
  );

  // independent reference: 64-bit arithmetic and signed integer compare
  function automatic bit ref_cond(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb2;
    sa  = longint'($signed(a));
    sb2 = longint'($signed(b));
    case (k)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return sa < sb2;
      3'd3: return a != 0;
      3'd4: return sa >= 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [25:0] j,
      input logic [31:0] im, input logic [31:0] a, input logic [31:0] b,
      input bit bb, input logic [2:0] k, input bit jj, input bit rr);
    longint unsigned s;
    s = longint'(p) + 4;
    if (rr) return a;
    if (jj) return (p & 32'hF000_0000) | (32'(j) * 4);
    if (bb && ref_cond(k, a, b)) begin
      s = s + longint'(im) * 4;
      return s[31:0];
    end
    return s[31:0];
  endfunction

  task automatic drive(input logic [31:0] p, input logic [25:0] j, input logic [31:0] im,
      input logic [31:0] a, input logic [31:0] b, input bit bb, input logic [2:0] k,
      input bit jj, input bit rr, input string tag);
    exp_t e;
    longint unsigned l;
    @(posedge clk);
    #1;
    pc = p; ja = j; imm = im; rs = a; rt = b; br = bb; kind = k; jp = jj; jr = rr;
    l = longint'(p) + 4;
    e.nxt = ref_next(p, j, im, a, b, bb, k, jj, rr);
    e.lnk = l[31:0];
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops at the falling edge after each drive
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_tests++;
      if (next_pc !== e.nxt) begin
        n_fail++;
        $display("FAIL %s next_pc act=%h exp=%h", e.tag, next_pc, e.nxt);
      end
      n_tests++;
      if (link !== e.lnk) begin
        n_fail++;
        $display("FAIL R1 (%s) link act=%h exp=%h", e.tag, link, e.lnk);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    pc = 0; ja = 0; imm = 0; rs = 0; rt = 0; br = 0; kind = 0; jp = 0; jr = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state / idle: all zero inputs -> next = 4
    drive(32'h0, 26'h0, 32'h0, 32'h0, 32'h0, 0, 3'd0, 0, 0, "R2 idle");
    drive(32'h0040_0010, 26'h0, 32'h5, 32'h1, 32'h1, 0, 3'd0, 0, 0, "R2 R7 no branch");
    // R4 equal / not-equal
    drive(32'h0040_0000, 26'h0, 32'h3, 32'h7, 32'h7, 1, 3'd0, 0, 0, "R4 eq taken");
    drive(32'h0040_0000, 26'h0, 32'h3, 32'h7, 32'h8, 1, 3'd0, 0, 0, "R4 eq not taken");
    drive(32'h0040_0000, 26'h0, 32'hFFFF_FFFE, 32'h7, 32'h8, 1, 3'd1, 0, 0, "R4 ne taken back");
    drive(32'h0040_0000, 26'h0, 32'h3, 32'h9, 32'h9, 1, 3'd1, 0, 0, "R4 ne not taken");
    // R5 signed less-than
    drive(32'h100, 26'h0, 32'h10, 32'hFFFF_FFFF, 32'h1, 1, 3'd2, 0, 0, "R5 -1<1 taken");
    drive(32'h100, 26'h0, 32'h10, 32'h1, 32'hFFFF_FFFF, 1, 3'd2, 0, 0, "R5 1<-1 not taken");
    drive(32'h100, 26'h0, 32'h10, 32'h8000_0000, 32'h7FFF_FFFF, 1, 3'd2, 0, 0, "R5 min<max");
    drive(32'h100, 26'h0, 32'h10, 32'h5, 32'h5, 1, 3'd2, 0, 0, "R5 equal not taken");
    // R6 not-zero / gez
    drive(32'h200, 26'h0, 32'h2, 32'h0, 32'h0, 1, 3'd3, 0, 0, "R6 nz zero");
    drive(32'h200, 26'h0, 32'h2, 32'h8000_0000, 32'h0, 1, 3'd3, 0, 0, "R6 nz neg");
    drive(32'h200, 26'h0, 32'h2, 32'h0, 32'h0, 1, 3'd4, 0, 0, "R6 gez zero");
    drive(32'h200, 26'h0, 32'h2, 32'hFFFF_FFFF, 32'h0, 1, 3'd4, 0, 0, "R6 gez neg");
    drive(32'h200, 26'h0, 32'h2, 32'h7FFF_FFFF, 32'h0, 1, 3'd4, 0, 0, "R6 gez max");
    // R11 reserved kinds
    for (int k = 5; k < 8; k++)
      drive(32'h300, 26'h0, 32'h8, 32'h1, 32'h1, 1, 3'(k), 0, 0, "R11 reserved kind");
    // R7 condition true but branch low
    drive(32'h300, 26'h0, 32'h8, 32'h4, 32'h4, 0, 3'd0, 0, 0, "R7 gated");
    // R3 wrap at top of address space
    drive(32'hFFFF_FFFC, 26'h0, 32'h1, 32'h0, 32'h0, 1, 3'd0, 0, 0, "R3 R1 wrap");
    drive(32'h0000_0004, 26'h0, 32'hFFFF_FFFC, 32'h0, 32'h0, 1, 3'd0, 0, 0, "R3 wrap under");
    // R8 direct jump
    drive(32'hA123_4560, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0, 0, 3'd0, 1, 0, "R8 jump");
    drive(32'h5000_0000, 26'h000_0001, 32'h0, 32'h0, 32'h0, 1, 3'd0, 1, 0, "R8 R10 jump over branch");
    // R9 register jump and R10 priority
    drive(32'h1000, 26'h12_3456, 32'h4, 32'hDEAD_BEE0, 32'hDEAD_BEE0, 1, 3'd0, 1, 1, "R9 R10 jr wins");
    drive(32'h1000, 26'h0, 32'h0, 32'h0000_0123, 32'h0, 0, 3'd0, 0, 1, "R9 jr");
    // random sweep
    for (int i = 0; i < 300; i++)
      drive($urandom, 26'($urandom), $urandom, $urandom, ($urandom % 4 == 0) ? 32'h0 : $urandom,
            1'($urandom), 3'($urandom), ($urandom % 5 == 0), ($urandom % 7 == 0), "R10 random");
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule